// File: doc/BRIEF.md
# Board Control Register Block

This block sits on a simple word-wide host bus and gives software a small set of board-level controls: an eight-segment LED bar, an eight-cell character display buffer, a soft-reset request, a general-purpose output byte and a handful of I2C control bits. The I2C lines to an attached serial EEPROM are bit-banged by software through one output register, and the data level the EEPROM drives back is visible in an input register. The LED bits and all display cells leave the block as parallel outputs for whatever renders them.

The display can be filled in two ways. A single 32-bit write to the word register turns the value into eight uppercase hexadecimal characters, most significant nibble in cell 0. A write to one of eight position registers replaces just one cell with the low byte of the data. Offsets 0x900 to 0x9FF belong to an external UART and this block neither answers nor acts on them.

Bus accesses are single-cycle strobes. Writes take effect at the clock edge that samples them; reads return data on `rdData` one cycle after `rdEn`.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset `ledBar`, `gpOut`, `i2cOe` and `i2cSel` are zero, `softResetReq` is low, `sclOut` and `sdaOut` are 1, and every display cell holds 0x20 (space).
- R2: A write to offset 0x008 stores data bits [7:0] on `ledBar`; a read of 0x008 returns them zero-extended.
- R3: A write to offset 0x410 sets display cell i (i = 0..7, on `dispChars[8i+7:8i]`) to the uppercase ASCII hex digit of data bits [31-4i:28-4i]: nibble n gives 0x30+n for n<10, 0x37+n otherwise.
- R4: A write to offset 0x418 + 8*i (i = 0..7) sets cell i to data bits [7:0] and leaves the other cells unchanged.
- R5: A write to offset 0x500 makes `softResetReq` high for exactly the one cycle after the write.
- R6: A read of offset 0x000 (switches) returns zero.
- R7: Offset 0xA00 holds an 8-bit `gpOut` (data [7:0]), 0xB08 a 2-bit `i2cOe` (data [1:0]), 0xB18 a 1-bit `i2cSel` (data [0]); each reads back zero-extended.
- R8: A write to offset 0xB10 drives `sclOut` from data bit 1 and `sdaOut` from data bit 0.
- R9: A read of offset 0xB00 returns bit 1 = last written SCL value, bit 0 = `sdaIn` sampled at the read edge, other bits zero.
- R10: Reads of unmapped offsets (including the 0x900..0x9FF window, offsets that are not multiples of 8 in the position range, and the write-only 0x410, 0x418.., 0x500, 0xB10) return zero; writes to unmapped offsets change no output.
- R11: `rdData` is valid in the cycle after `rdEn` and is zero in any cycle not following a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 20 | Byte offset of the access |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after rdEn |
| ledBar | output | 8 | LED bar bits |
| dispChars | output | 64 | Display cells, cell i in bits [8i+7:8i] |
| softResetReq | output | 1 | One-cycle system reset request |
| gpOut | output | 8 | General-purpose output byte |
| i2cOe | output | 2 | I2C output-enable bits |
| i2cSel | output | 1 | I2C select bit |
| sclOut | output | 1 | SCL level toward the EEPROM |
| sdaOut | output | 1 | SDA level toward the EEPROM |
| sdaIn | input | 1 | SDA level driven by the EEPROM |

## Verification
Every write result is due at the edge that samples the write, so the bench drives a strobe on a falling edge, removes it on the next falling edge and samples the outputs right there, one rising edge later. Read data is registered, so the bench samples `rdData` at the falling edge following the rising edge that saw `rdEn`, with `sdaIn` settled before that edge. The reset pulse is checked high at the first falling edge after the write and low at the next, which pins its one-cycle width.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
  localparam int OFF_W     = 20;
  localparam int DATA_W    = 32;
  localparam int CHAR_W    = 8;
  localparam int NUM_CHARS = 8;
  localparam int IDX_W     = $clog2(NUM_CHARS);
  localparam int BYTE_W    = 8;

  localparam logic [OFF_W-1:0] OFF_SWITCH = 20'h00000;
  localparam logic [OFF_W-1:0] OFF_LED    = 20'h00008;
  localparam logic [OFF_W-1:0] OFF_WORD   = 20'h00410;
  localparam logic [OFF_W-1:0] OFF_POS0   = 20'h00418;
  localparam logic [OFF_W-1:0] OFF_SOFTRS = 20'h00500;
  localparam logic [OFF_W-1:0] OFF_GPOUT  = 20'h00A00;
  localparam logic [OFF_W-1:0] OFF_I2CIN  = 20'h00B00;
  localparam logic [OFF_W-1:0] OFF_I2COE  = 20'h00B08;
  localparam logic [OFF_W-1:0] OFF_I2COUT = 20'h00B10;
  localparam logic [OFF_W-1:0] OFF_I2CSEL = 20'h00B18;

  localparam logic [CHAR_W-1:0] BLANK_CHAR = 8'h20;

  typedef enum logic [2:0] {
    RD_ZERO, RD_LED, RD_GPOUT, RD_I2CIN, RD_I2COE, RD_I2CSEL
  } rdSel_e;

  typedef struct packed {
    logic             wrLed;
    logic             wrWord;
    logic             wrPos;
    logic [IDX_W-1:0] posIdx;
    logic             wrSoftRst;
    logic             wrGpout;
    logic             wrI2cOe;
    logic             wrI2cOut;
    logic             wrI2cSel;
    logic             rdHit;
    rdSel_e           rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
  import board_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] busAddr,
  input  logic             wrEn,
  input  logic             rdEn,
  output ctrlStrobe_t      strobe
);
  localparam logic [OFF_W-4:0] POS_CNT = (OFF_W-3)'(NUM_CHARS);

  logic [OFF_W-1:0] posDelta;
  logic             inPos;

  assign posDelta = busAddr - OFF_POS0;
  assign inPos    = (busAddr >= OFF_POS0) && (posDelta[2:0] == 3'b000) &&
                    (posDelta[OFF_W-1:3] < POS_CNT);

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = RD_ZERO;
    strobe.posIdx    = posDelta[3 +: IDX_W];
    strobe.wrLed     = wrEn && (busAddr == OFF_LED);
    strobe.wrWord    = wrEn && (busAddr == OFF_WORD);
    strobe.wrPos     = wrEn && inPos;
    strobe.wrSoftRst = wrEn && (busAddr == OFF_SOFTRS);
    strobe.wrGpout   = wrEn && (busAddr == OFF_GPOUT);
    strobe.wrI2cOe   = wrEn && (busAddr == OFF_I2COE);
    strobe.wrI2cOut  = wrEn && (busAddr == OFF_I2COUT);
    strobe.wrI2cSel  = wrEn && (busAddr == OFF_I2CSEL);
    strobe.rdHit     = rdEn;
    if (rdEn) begin
      unique case (busAddr)
        OFF_SWITCH: strobe.rdSel = RD_ZERO;
        OFF_LED:    strobe.rdSel = RD_LED;
        OFF_GPOUT:  strobe.rdSel = RD_GPOUT;
        OFF_I2CIN:  strobe.rdSel = RD_I2CIN;
        OFF_I2COE:  strobe.rdSel = RD_I2COE;
        OFF_I2CSEL: strobe.rdSel = RD_I2CSEL;
        default:    strobe.rdSel = RD_ZERO;
      endcase
    end
  end

  // At most one write target per cycle (R10)
  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrLed, strobe.wrWord, strobe.wrPos, strobe.wrSoftRst,
              strobe.wrGpout, strobe.wrI2cOe, strobe.wrI2cOut, strobe.wrI2cSel}));

  // The UART window never produces a strobe (R10)
  p_uart_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr[OFF_W-1:8] == 12'h009) |->
      !(strobe.wrLed || strobe.wrWord || strobe.wrPos || strobe.wrSoftRst ||
        strobe.wrGpout || strobe.wrI2cOe || strobe.wrI2cOut || strobe.wrI2cSel) &&
      (strobe.rdSel == RD_ZERO));
endmodule

// File: rtl/board_ctrl_datapath.sv
module board_ctrl_datapath
  import board_ctrl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlStrobe_t                 strobe,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        sdaIn,
  output logic [DATA_W-1:0]           rdData,
  output logic [BYTE_W-1:0]           ledBar,
  output logic [NUM_CHARS*CHAR_W-1:0] dispChars,
  output logic                        softResetReq,
  output logic [BYTE_W-1:0]           gpOut,
  output logic [1:0]                  i2cOe,
  output logic                        i2cSel,
  output logic                        sclOut,
  output logic                        sdaOut
);
  function automatic logic [CHAR_W-1:0] hexChar(input logic [3:0] nib);
    if (nib < 4'd10) hexChar = 8'h30 + {4'h0, nib};
    else             hexChar = 8'h37 + {4'h0, nib};
  endfunction

  logic [CHAR_W-1:0] dispReg [NUM_CHARS];
  logic [DATA_W-1:0] rdNext;

  for (genvar c = 0; c < NUM_CHARS; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        dispReg[c] <= BLANK_CHAR;
      else if (strobe.wrWord)
        dispReg[c] <= hexChar(wrData[DATA_W-1-4*c -: 4]);
      else if (strobe.wrPos && (strobe.posIdx == IDX_W'(c)))
        dispReg[c] <= wrData[CHAR_W-1:0];
    end
    assign dispChars[c*CHAR_W +: CHAR_W] = dispReg[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ledBar       <= '0;
      gpOut        <= '0;
      i2cOe        <= '0;
      i2cSel       <= 1'b0;
      sclOut       <= 1'b1;
      sdaOut       <= 1'b1;
      softResetReq <= 1'b0;
    end else begin
      softResetReq <= strobe.wrSoftRst;
      if (strobe.wrLed)    ledBar <= wrData[BYTE_W-1:0];
      if (strobe.wrGpout)  gpOut  <= wrData[BYTE_W-1:0];
      if (strobe.wrI2cOe)  i2cOe  <= wrData[1:0];
      if (strobe.wrI2cSel) i2cSel <= wrData[0];
      if (strobe.wrI2cOut) begin
        sclOut <= wrData[1];
        sdaOut <= wrData[0];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      RD_LED:    rdNext[BYTE_W-1:0] = ledBar;
      RD_GPOUT:  rdNext[BYTE_W-1:0] = gpOut;
      RD_I2CIN:  rdNext[1:0]        = {sclOut, sdaIn};
      RD_I2COE:  rdNext[1:0]        = i2cOe;
      RD_I2CSEL: rdNext[0]          = i2cSel;
      default:   rdNext             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            rdData <= '0;
    else if (strobe.rdHit) rdData <= rdNext;
    else                   rdData <= '0;
  end

  p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrLed |=> $stable(ledBar));

  p_disp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.wrWord || strobe.wrPos) |=> $stable(dispChars));

  p_soft_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrSoftRst |=> softResetReq);

  p_soft_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrSoftRst |=> !softResetReq);

  p_i2c_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrI2cOut |=> (sclOut == $past(wrData[1])) && (sdaOut == $past(wrData[0])));

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rdHit |=> (rdData == '0));
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [OFF_W-1:0]            busAddr,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output logic [BYTE_W-1:0]           ledBar,
  output logic [NUM_CHARS*CHAR_W-1:0] dispChars,
  output logic                        softResetReq,
  output logic [BYTE_W-1:0]           gpOut,
  output logic [1:0]                  i2cOe,
  output logic                        i2cSel,
  output logic                        sclOut,
  output logic                        sdaOut,
  input  logic                        sdaIn
);
  ctrlStrobe_t strobe;

  board_ctrl_decode decode_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobe  (strobe)
  );

  board_ctrl_datapath datapath_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .wrData       (wrData),
    .sdaIn        (sdaIn),
    .rdData       (rdData),
    .ledBar       (ledBar),
    .dispChars    (dispChars),
    .softResetReq (softResetReq),
    .gpOut        (gpOut),
    .i2cOe        (i2cOe),
    .i2cSel       (i2cSel),
    .sclOut       (sclOut),
    .sdaOut       (sdaOut)
  );
endmodule

// File: tb/board_ctrl_regs_tb.sv
module board_ctrl_regs_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] busAddr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0]  ledBar;
  logic [63:0] dispChars;
  logic        softResetReq;
  logic [7:0]  gpOut;
  logic [1:0]  i2cOe;
  logic        i2cSel;
  logic        sclOut;
  logic        sdaOut;
  logic        sdaIn = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] expDisp [8];

  board_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .ledBar(ledBar), .dispChars(dispChars),
    .softResetReq(softResetReq), .gpOut(gpOut), .i2cOe(i2cOe), .i2cSel(i2cSel),
    .sclOut(sclOut), .sdaOut(sdaOut), .sdaIn(sdaIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  function automatic logic [7:0] hexOf(input logic [3:0] n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic logic [63:0] packDisp();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = expDisp[i];
    return v;
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] words [5];
    words[0] = 32'h0123ABCD; words[1] = 32'hFFFFFFFF; words[2] = 32'h00000000;
    words[3] = 32'hDEADBEEF; words[4] = 32'h9A5C3E71;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) expDisp[i] = 8'h20;
    check("R1 led", 64'(ledBar), 64'h0);
    check("R1 gpout", 64'(gpOut), 64'h0);
    check("R1 i2cOe", 64'(i2cOe), 64'h0);
    check("R1 i2cSel", 64'(i2cSel), 64'h0);
    check("R1 softReset", 64'(softResetReq), 64'h0);
    check("R1 scl/sda", 64'({sclOut, sdaOut}), 64'h3);
    check("R1 display", dispChars, packDisp());
    check("R11 idle rdData", 64'(rdData), 64'h0);

    // R2 LED sweep
    for (int v = 0; v < 256; v++) begin
      busWrite(20'h00008, {24'hA5C3F0, 8'(v)});
      check("R2 ledBar", 64'(ledBar), 64'(v));
      busRead(20'h00008, rd);
      check("R2 led readback", 64'(rd), 64'(v));
    end

    // R3 ASCII word
    for (int w = 0; w < 5; w++) begin
      busWrite(20'h00410, words[w]);
      for (int i = 0; i < 8; i++) expDisp[i] = hexOf(words[w][31-4*i -: 4]);
      check("R3 hex word", dispChars, packDisp());
    end

    // R4 per-cell position writes
    for (int i = 0; i < 8; i++) begin
      busWrite(20'h00418 + 20'(8*i), {24'hFFFF00, 8'(8'h61 + i)});
      expDisp[i] = 8'(8'h61 + i);
      check("R4 position cell", dispChars, packDisp());
    end

    // R5 soft reset pulse
    busWrite(20'h00500, 32'h0);
    check("R5 pulse high", 64'(softResetReq), 64'h1);
    @(negedge clk);
    check("R5 pulse low", 64'(softResetReq), 64'h0);

    // R6 switches
    busRead(20'h00000, rd);
    check("R6 switch zero", 64'(rd), 64'h0);

    // R7 gpout, i2cOe, i2cSel
    for (int v = 0; v < 256; v++) begin
      busWrite(20'h00A00, {24'h5A5A5A, 8'(v)});
      check("R7 gpOut", 64'(gpOut), 64'(v));
      busRead(20'h00A00, rd);
      check("R7 gpOut readback", 64'(rd), 64'(v));
    end
    for (int v = 0; v < 8; v++) begin
      busWrite(20'h00B08, {29'h1FFFFFF0, 3'(v)});
      check("R7 i2cOe", 64'(i2cOe), 64'(v % 4));
      busRead(20'h00B08, rd);
      check("R7 i2cOe readback", 64'(rd), 64'(v % 4));
      busWrite(20'h00B18, {30'h3FFFFFF0, 2'(v)});
      check("R7 i2cSel", 64'(i2cSel), 64'(v % 2));
      busRead(20'h00B18, rd);
      check("R7 i2cSel readback", 64'(rd), 64'(v % 2));
    end

    // R8 / R9 I2C lines
    for (int v = 0; v < 4; v++) begin
      busWrite(20'h00B10, {30'h2AAAAAAA, 2'(v)});
      check("R8 scl", 64'(sclOut), 64'((v >> 1) & 1));
      check("R8 sda", 64'(sdaOut), 64'(v & 1));
      for (int s = 0; s < 2; s++) begin
        sdaIn = 1'(s);
        busRead(20'h00B00, rd);
        check("R9 i2c input", 64'(rd), 64'(((v >> 1) & 1) * 2 + s));
      end
    end
    sdaIn = 1'b0;

    // R10 unmapped writes and reads
    busWrite(20'h00008, 32'h3C);
    busWrite(20'h00A00, 32'h96);
    begin
      logic [19:0] bad [6];
      bad[0] = 20'h00900; bad[1] = 20'h009F8; bad[2] = 20'h0041C;
      bad[3] = 20'h00004; bad[4] = 20'h00458; bad[5] = 20'hFFFF8;
      for (int k = 0; k < 6; k++) begin
        busWrite(bad[k], 32'hFFFFFFFF);
        check("R10 led unchanged", 64'(ledBar), 64'h3C);
        check("R10 gpOut unchanged", 64'(gpOut), 64'h96);
        check("R10 display unchanged", dispChars, packDisp());
        check("R10 no reset pulse", 64'(softResetReq), 64'h0);
        busRead(bad[k], rd);
        check("R10 unmapped read", 64'(rd), 64'h0);
      end
      busRead(20'h00410, rd);
      check("R10 word reg reads zero", 64'(rd), 64'h0);
      busRead(20'h00B10, rd);
      check("R10 i2c out reads zero", 64'(rd), 64'h0);
    end

    // R11 rdData returns to zero after a read
    busRead(20'h00008, rd);
    check("R11 read data", 64'(rd), 64'h3C);
    @(negedge clk);
    check("R11 rdData cleared", 64'(rdData), 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule